// File: doc/BRIEF.md
# Left-Rotating Barrel Shifter with Decoded Fill Mask

A purely combinational shifter for a 32-bit datapath. One logarithmic array performs every operation by rotating its input left. Right shifts and right rotations reach the array as a left rotation by the two's complement of the distance. The set of bit positions that a shift vacates does not depend on the rotated data. It is decoded straight from the shift distance and the operation code, in parallel with the array. A final merge stage keeps the rotated bits outside that mask and puts the selected fill value into the positions inside it.

The operation code selects logical left or right shift, arithmetic right shift, left or right rotation, and left or right shift that fills the vacated bits with an external fill bit. The block holds no state. It sits between operand registers and a result register of the surrounding datapath.

Top module: `lrot_shifter`

## Requirements
- R1: With `op`=3'b000 (logical left), `dout` equals `din` shifted left by `amt`, and the low `amt` bits are 0.
- R2: With `op`=3'b001 (logical right), `dout` equals `din` shifted right by `amt`, and the top `amt` bits are 0.
- R3: With `op`=3'b010 (arithmetic right), `dout` equals `din` shifted right by `amt`, and the top `amt` bits are copies of `din[31]`.
- R4: With `op`=3'b011 (rotate left), `dout` equals `din` rotated left by `amt`, and no bit is lost. The code 3'b111 behaves identically.
- R5: With `op`=3'b100 (rotate right), `dout` equals `din` rotated right by `amt`.
- R6: With `op`=3'b101 (left with fill), `dout` equals `din` shifted left by `amt`, and the low `amt` bits equal `fill_bit`.
- R7: With `op`=3'b110 (right with fill), `dout` equals `din` shifted right by `amt`, and the top `amt` bits equal `fill_bit`.
- R8: When `amt` is 0, `dout` equals `din` in every mode.
- R9: `fill_bit` has no effect on `dout` in any mode other than 3'b101 and 3'b110.
- R10: The number of replaced positions equals `amt` in every shift mode and is zero in both rotate modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 32 | Operand word |
| amt | input | 5 | Shift or rotate distance, 0 to 31 |
| op | input | 3 | Operation code, see R1 to R7 |
| fill_bit | input | 1 | Value written into vacated bits in the fill modes |
| dout | output | 32 | Result word |

## Verification
The in-module assertions assume that every input is a known 0 or 1. They are skipped while any input is unknown, so they cannot fire before the bench first drives the ports. They also assume that the width is a power of two, which makes the two's-complement distance used for right operations a correct rotation count. The bench drives all inputs at the start of time and changes them only at a clock edge. It checks the output half a period later, after the combinational logic has settled. Across all tests it covers all 32 distances, all eight operation codes and both fill values.

// File: rtl/lrot_shifter.sv
module lrot_shifter #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic [2:0]    op,
  input  logic          fill_bit,
  output logic [W-1:0]  dout
);
  localparam logic [2:0] OP_SLL = 3'b000, OP_SRL = 3'b001, OP_SRA = 3'b010,
                         OP_ROL = 3'b011, OP_ROR = 3'b100, OP_SLF = 3'b101,
                         OP_SRF = 3'b110, OP_RSV = 3'b111;

  logic          go_right, is_rot;
  logic [SW-1:0] rot_amt;
  logic          fill_val;
  logic [W-1:0]  lo_m, hi_m, mask;
  logic [W-1:0]  stg [0:SW];

  // option decoder
  assign go_right = (op == OP_SRL) || (op == OP_SRA) || (op == OP_ROR) || (op == OP_SRF);
  assign is_rot   = (op == OP_ROL) || (op == OP_ROR) || (op == OP_RSV);
  always_comb begin
    case (op)
      OP_SRA:         fill_val = din[W-1];
      OP_SLF, OP_SRF: fill_val = fill_bit;
      default:        fill_val = 1'b0;
    endcase
  end

  // scale-factor decoder: right moves become a left rotation by -amt
  assign rot_amt = go_right ? SW'(-amt) : amt;

  // mask decoder, driven from the distance only
  for (genvar i = 0; i < W; i++) begin : g_mask
    assign lo_m[i]       = ({1'b0, SW'(i)} < {1'b0, amt});
    assign hi_m[W-1-i]   = lo_m[i];
  end
  assign mask = is_rot ? '0 : (go_right ? hi_m : lo_m);

  // left-only rotation array
  assign stg[0] = din;
  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stg[k+1] = rot_amt[k] ? {stg[k][W-1-SH:0], stg[k][W-1:W-SH]} : stg[k];
  end

  // merge
  assign dout = (stg[SW] & ~mask) | ({W{fill_val}} & mask);

  always_comb begin
    if (!$isunknown({din, amt, op, fill_bit})) begin
      p_zero_amt_passes_r8: assert (amt != '0 || dout == din)
        else $error("R8 zero distance altered data");
      p_mask_width_r10: assert ($countones(mask) == (is_rot ? 0 : int'(amt)))
        else $error("R10 mask population wrong");
      p_rotate_keeps_bits_r4: assert (!is_rot || $countones(dout) == $countones(din))
        else $error("R4 rotate changed bit count");
      p_sra_sign_top_r3: assert (op != OP_SRA || dout[W-1] == din[W-1])
        else $error("R3 sign bit lost");
      p_sll_low_zero_r1: assert (op != OP_SLL || amt == '0 || dout[0] == 1'b0)
        else $error("R1 vacated low bit not zero");
      p_srf_top_fill_r7: assert (op != OP_SRF || amt == '0 || dout[W-1] == fill_bit)
        else $error("R7 vacated top bit not fill");
    end
  end
endmodule

// File: tb/lrot_shifter_tb.sv
module lrot_shifter_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] din = '0;
  logic [4:0]  amt = '0;
  logic [2:0]  op = '0;
  logic        fill_bit = 1'b0;
  logic [31:0] dout;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  lrot_shifter dut_i (.din(din), .amt(amt), .op(op), .fill_bit(fill_bit), .dout(dout));

  function automatic logic [31:0] pat(input int p);
    case (p)
      0: return 32'h8000_0001;
      1: return 32'hDEAD_BEEF;
      2: return 32'h7FFF_FFFE;
      default: return 32'h1234_5678;
    endcase
  endfunction

  task automatic apply_check(input logic [2:0] o, input logic [31:0] d, input int n,
                             input logic f, input logic [31:0] exp, input string req);
    @(posedge clk);
    op = o; din = d; amt = 5'(n); fill_bit = f;
    @(negedge clk);
    n_chk++;
    if (dout !== exp) begin
      n_bad++;
      $display("FAIL %s op=%b amt=%0d fill=%b actual=%h expected=%h", req, o, n, f, dout, exp);
    end
  endtask

  task automatic t_sll_r1();
    for (int p = 0; p < 4; p++) for (int n = 0; n < 32; n++) for (int f = 0; f < 2; f++)
      apply_check(3'b000, pat(p), n, 1'(f), pat(p) << n, "R1/R9");
  endtask

  task automatic t_srl_r2();
    for (int p = 0; p < 4; p++) for (int n = 0; n < 32; n++) for (int f = 0; f < 2; f++)
      apply_check(3'b001, pat(p), n, 1'(f), pat(p) >> n, "R2/R9");
  endtask

  task automatic t_sra_r3();
    for (int p = 0; p < 4; p++) for (int n = 0; n < 32; n++) for (int f = 0; f < 2; f++)
      apply_check(3'b010, pat(p), n, 1'(f), 32'($signed(pat(p)) >>> n), "R3/R9");
  endtask

  task automatic t_rol_r4();
    for (int p = 0; p < 4; p++) for (int n = 0; n < 32; n++) for (int f = 0; f < 2; f++) begin
      apply_check(3'b011, pat(p), n, 1'(f), (pat(p) << n) | (pat(p) >> (32 - n)), "R4/R9");
      apply_check(3'b111, pat(p), n, 1'(f), (pat(p) << n) | (pat(p) >> (32 - n)), "R4");
    end
  endtask

  task automatic t_ror_r5();
    for (int p = 0; p < 4; p++) for (int n = 0; n < 32; n++) for (int f = 0; f < 2; f++)
      apply_check(3'b100, pat(p), n, 1'(f), (pat(p) >> n) | (pat(p) << (32 - n)), "R5/R9");
  endtask

  task automatic t_slf_r6();
    for (int p = 0; p < 4; p++) for (int n = 0; n < 32; n++) for (int f = 0; f < 2; f++)
      apply_check(3'b101, pat(p), n, 1'(f),
                  (pat(p) << n) | (f ? ~(32'hFFFF_FFFF << n) : 32'h0), "R6");
  endtask

  task automatic t_srf_r7();
    for (int p = 0; p < 4; p++) for (int n = 0; n < 32; n++) for (int f = 0; f < 2; f++)
      apply_check(3'b110, pat(p), n, 1'(f),
                  (pat(p) >> n) | (f ? ~(32'hFFFF_FFFF >> n) : 32'h0), "R7");
  endtask

  task automatic t_zero_r8();
    for (int o = 0; o < 8; o++) for (int f = 0; f < 2; f++)
      apply_check(3'(o), 32'hA5C3_0F96, 0, 1'(f), 32'hA5C3_0F96, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    n_chk++;
    if (dout !== 32'h0) begin
      n_bad++;
      $display("FAIL R1 initial actual=%h expected=%h", dout, 32'h0);
    end
    t_zero_r8();
    t_sll_r1();
    t_srl_r2();
    t_sra_r3();
    t_rol_r4();
    t_ror_r5();
    t_slf_r6();
    t_srf_r7();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule